// File: doc/BRIEF.md
# Interleaved-Parity Error Accumulator

This block takes, once per frame, a locally computed 8-bit interleaved parity byte and the parity byte received in the frame. It counts two things: the number of bit positions in which the two bytes differ (bit errors), and the number of frames in which they differ at all (block errors). Both counts build up in saturating accumulators. The bit-error accumulator is 24 bits wide and the block-error accumulator is 20 bits wide.

An external once-per-second tick copies both accumulators into snapshot registers that a processor can read. A mode input selects what happens to the accumulators on that copy: they either restart from zero or keep running. Counting stops while the line is in a defect state. Loss of frame and loss of signal always stop it. Out-of-frame and incoming alignment error stop it only when their own enable inputs are set. Any counted errored frame sets a sticky flag. The flag, gated by a mask input, drives an interrupt line.

Top module: `parity_err_monitor`

## Requirements
- R1: After reset both snapshots read 0, and the error flag and the interrupt are 0.
- R2: A counted frame adds to the bit-error accumulator the number of 1 bits in the XOR of the calculated and received parity bytes.
- R3: A counted frame adds exactly 1 to the block-error accumulator when the two parity bytes differ, and 0 when they are equal.
- R4: When the tick is high at a clock edge, each snapshot takes the value its accumulator held before that edge. A frame strobed in the same cycle is not included. With the tick low, the snapshots hold their values.
- R5: When the tick is high and the clear mode is 1, the accumulators restart from zero, and a frame counted in the same cycle goes into the new interval. When the clear mode is 0, the accumulators keep their value across the tick.
- R6: A frame strobed while loss of frame or loss of signal is high adds nothing.
- R7: Out-of-frame blocks counting only when its enable is 1. Incoming alignment error blocks counting only when its enable is 1. With an enable at 0, the matching condition has no effect.
- R8: Each accumulator saturates at its all-ones value and does not wrap.
- R9: A counted frame with differing parity sets the sticky error flag. A clear pulse resets the flag. A set in the same cycle as a clear wins. A paused frame does not set the flag.
- R10: The interrupt equals the error flag ANDed with the mask input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe: parity bytes valid for one frame |
| calc_par | input | 8 | Locally computed parity byte |
| rx_par | input | 8 | Received parity byte |
| sec_tick | input | 1 | One-second transfer tick |
| clr_on_xfer | input | 1 | 1: accumulators restart on transfer; 0: retain |
| lof | input | 1 | Loss of frame |
| los | input | 1 | Loss of signal |
| oof | input | 1 | Out of frame |
| oof_pause_en | input | 1 | Enable out-of-frame pause |
| iae | input | 1 | Incoming alignment error |
| iae_pause_en | input | 1 | Enable alignment-error pause |
| err_flag_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| err_irq_mask | input | 1 | Interrupt enable for the error flag |
| bit_err_snap | output | 24 | Bit-error snapshot |
| blk_err_snap | output | 20 | Block-error snapshot |
| err_flag | output | 1 | Sticky parity-error flag |
| err_irq | output | 1 | Masked interrupt |

## Verification
Each accumulator and the flag register the frame at the clock edge where it is strobed. A snapshot shows an accumulator's value one edge after a tick. The bit and block results therefore appear at the ports one tick-transfer later than the frame that produced them. The flag is visible one edge after its frame, and the interrupt follows the mask combinationally. The bench drives inputs at the falling edge and updates its model at the rising edge from those inputs. It compares every output at the next falling edge, so each expected value is checked in the cycle it becomes due. A second, narrow instance makes saturation reachable in a few dozen frames.

// File: rtl/perr_pkg.sv
package perr_pkg;
  // Number of set bits in a 64-bit vector; callers zero-extend narrower words.
  function automatic logic [6:0] ones64(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + {6'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/parity_cmp.sv
module parity_cmp #(
  parameter int PAR_W  = 8,
  localparam int ONES_W = $clog2(PAR_W + 1)
) (
  input  logic [PAR_W-1:0]  calc,
  input  logic [PAR_W-1:0]  rcvd,
  output logic [ONES_W-1:0] diff_ones,
  output logic              any_diff
);
  import perr_pkg::*;
  logic [PAR_W-1:0] diff;
  logic [6:0]       ones_full;
  assign diff      = calc ^ rcvd;
  assign ones_full = ones64(64'(diff));
  assign diff_ones = ONES_W'(ones_full);
  assign any_diff  = |diff;
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int ACC_W = 24,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc,
  input  logic             xfer,
  input  logic             clr_on_xfer,
  output logic [ACC_W-1:0] acc
);
  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W + 1)'(b);
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] base, acc_nxt;
  assign base    = (xfer && clr_on_xfer) ? '0 : acc;
  assign acc_nxt = inc_en ? sat_add(base, inc) : base;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/parity_err_monitor.sv
module parity_err_monitor #(
  parameter int PAR_W     = 8,
  parameter int BIT_CNT_W = 24,
  parameter int BLK_CNT_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_vld,
  input  logic [PAR_W-1:0]     calc_par,
  input  logic [PAR_W-1:0]     rx_par,
  input  logic                 sec_tick,
  input  logic                 clr_on_xfer,
  input  logic                 lof,
  input  logic                 los,
  input  logic                 oof,
  input  logic                 oof_pause_en,
  input  logic                 iae,
  input  logic                 iae_pause_en,
  input  logic                 err_flag_clr,
  input  logic                 err_irq_mask,
  output logic [BIT_CNT_W-1:0] bit_err_snap,
  output logic [BLK_CNT_W-1:0] blk_err_snap,
  output logic                 err_flag,
  output logic                 err_irq
);
  localparam int ONES_W = $clog2(PAR_W + 1);

  // Named internal events, observed by the bound checker.
  logic              paused;
  logic              frame_counted;
  logic              frame_errored;
  logic [ONES_W-1:0] bits_inc;
  logic [BIT_CNT_W-1:0] bit_acc;
  logic [BLK_CNT_W-1:0] blk_acc;

  assign paused        = lof || los || (oof && oof_pause_en) || (iae && iae_pause_en);
  assign frame_counted = frame_vld && !paused;

  parity_cmp #(.PAR_W(PAR_W)) u_cmp (
    .calc      (calc_par),
    .rcvd      (rx_par),
    .diff_ones (bits_inc),
    .any_diff  (frame_errored)
  );

  sat_accum #(.ACC_W(BIT_CNT_W), .INC_W(ONES_W)) u_bit_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_en      (frame_counted),
    .inc         (bits_inc),
    .xfer        (sec_tick),
    .clr_on_xfer (clr_on_xfer),
    .acc         (bit_acc)
  );

  sat_accum #(.ACC_W(BLK_CNT_W), .INC_W(1)) u_blk_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_en      (frame_counted),
    .inc         (frame_errored),
    .xfer        (sec_tick),
    .clr_on_xfer (clr_on_xfer),
    .acc         (blk_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_err_snap <= '0;
      blk_err_snap <= '0;
    end else if (sec_tick) begin
      bit_err_snap <= bit_acc;
      blk_err_snap <= blk_acc;
    end
  end

  sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (frame_counted && frame_errored),
    .clr   (err_flag_clr),
    .q     (err_flag)
  );

  assign err_irq = err_flag && err_irq_mask;
endmodule

// File: rtl/perr_checker.sv
module perr_checker #(
  parameter int BIT_CNT_W = 24,
  parameter int BLK_CNT_W = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sec_tick,
  input logic                 clr_on_xfer,
  input logic                 lof,
  input logic                 los,
  input logic                 err_flag_clr,
  input logic                 frame_counted,
  input logic                 frame_errored,
  input logic [BIT_CNT_W-1:0] bit_acc,
  input logic [BLK_CNT_W-1:0] blk_acc,
  input logic [BIT_CNT_W-1:0] bit_err_snap,
  input logic [BLK_CNT_W-1:0] blk_err_snap,
  input logic                 err_flag
);
  a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(bit_err_snap) && $stable(blk_err_snap));

  a_r4_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> bit_err_snap == $past(bit_acc) && blk_err_snap == $past(blk_acc));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && clr_on_xfer && !frame_counted |=> bit_acc == '0 && blk_acc == '0);

  a_r6_defect_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (lof || los) && !sec_tick |=> $stable(bit_acc) && $stable(blk_acc));

  a_r3_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_counted && frame_errored && !sec_tick && blk_acc != '1
      |=> blk_acc == BLK_CNT_W'($past(blk_acc) + 1'b1));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    bit_acc == '1 && !sec_tick |=> bit_acc == '1);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_counted && frame_errored |=> err_flag);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag_clr && !(frame_counted && frame_errored) |=> !err_flag);
endmodule

bind parity_err_monitor perr_checker #(
  .BIT_CNT_W (BIT_CNT_W),
  .BLK_CNT_W (BLK_CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sec_tick      (sec_tick),
  .clr_on_xfer   (clr_on_xfer),
  .lof           (lof),
  .los           (los),
  .err_flag_clr  (err_flag_clr),
  .frame_counted (frame_counted),
  .frame_errored (frame_errored),
  .bit_acc       (bit_acc),
  .blk_acc       (blk_acc),
  .bit_err_snap  (bit_err_snap),
  .blk_err_snap  (blk_err_snap),
  .err_flag      (err_flag)
);

// File: tb/tb_parity_err_monitor.sv
module tb_parity_err_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_vld = 0, sec_tick = 0, clr_on_xfer = 0;
  logic [7:0] calc_par = 0, rx_par = 0;
  logic lof = 0, los = 0, oof = 0, oof_pause_en = 0, iae = 0, iae_pause_en = 0;
  logic err_flag_clr = 0, err_irq_mask = 0;
  logic [23:0] bit_err_snap;
  logic [19:0] blk_err_snap;
  logic err_flag, err_irq;
  logic [5:0] s_bit_snap;
  logic [3:0] s_blk_snap;
  logic s_flag, s_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  parity_err_monitor dut (
    .clk, .rst_n, .frame_vld, .calc_par, .rx_par, .sec_tick, .clr_on_xfer,
    .lof, .los, .oof, .oof_pause_en, .iae, .iae_pause_en, .err_flag_clr,
    .err_irq_mask, .bit_err_snap, .blk_err_snap, .err_flag, .err_irq
  );

  parity_err_monitor #(.BIT_CNT_W(6), .BLK_CNT_W(4)) dut_sat (
    .clk, .rst_n, .frame_vld, .calc_par, .rx_par, .sec_tick, .clr_on_xfer,
    .lof, .los, .oof, .oof_pause_en, .iae, .iae_pause_en, .err_flag_clr,
    .err_irq_mask, .bit_err_snap(s_bit_snap), .blk_err_snap(s_blk_snap),
    .err_flag(s_flag), .err_irq(s_irq)
  );

  // Reference model state
  longint m_bit, m_blk, m_sbit, m_sblk;   // wide instance
  longint n_bit, n_blk, n_sbit, n_sblk;   // narrow instance
  bit     m_flag;

  function automatic longint bits_differ(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x = a ^ b;
    longint c = 0;
    while (x != 0) begin x = x & (x - 8'd1); c++; end
    return c;
  endfunction

  function automatic longint clamp_add(input longint a, input longint b, input int w);
    longint lim = (longint'(1) << w) - 1;
    return (a + b > lim) ? lim : a + b;
  endfunction

  function automatic bit is_paused();
    return lof || los || (oof && oof_pause_en) || (iae && iae_pause_en);
  endfunction

  task automatic model_reset();
    m_bit = 0; m_blk = 0; m_sbit = 0; m_sblk = 0;
    n_bit = 0; n_blk = 0; n_sbit = 0; n_sblk = 0; m_flag = 0;
  endtask

  task automatic model_step();
    bit cnt = frame_vld && !is_paused();
    longint db = bits_differ(calc_par, rx_par);
    longint dk = (db != 0) ? 1 : 0;
    if (sec_tick) begin
      m_sbit = m_bit; m_sblk = m_blk; n_sbit = n_bit; n_sblk = n_blk;
      if (clr_on_xfer) begin m_bit = 0; m_blk = 0; n_bit = 0; n_blk = 0; end
    end
    if (cnt) begin
      m_bit = clamp_add(m_bit, db, 24); m_blk = clamp_add(m_blk, dk, 20);
      n_bit = clamp_add(n_bit, db, 6);  n_blk = clamp_add(n_blk, dk, 4);
    end
    if (cnt && dk != 0) m_flag = 1;
    else if (err_flag_clr) m_flag = 0;
  endtask

  task automatic check(input bit ok, input string req, input string ph,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, ph, act, exp);
    end
  endtask

  task automatic compare(input string ph);
    check(bit_err_snap == 24'(m_sbit), "R2", ph, bit_err_snap, m_sbit);
    check(blk_err_snap == 20'(m_sblk), "R3", ph, blk_err_snap, m_sblk);
    check(err_flag == m_flag, "R9", ph, err_flag, m_flag);
    check(err_irq == (m_flag && err_irq_mask), "R10", ph, err_irq, m_flag && err_irq_mask);
    check(s_bit_snap == 6'(n_sbit), "R8", ph, s_bit_snap, n_sbit);
    check(s_blk_snap == 4'(n_sblk), "R8", ph, s_blk_snap, n_sblk);
  endtask

  // One clock: inputs already driven; model at posedge; compare at negedge.
  task automatic cyc(input string ph);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(ph);
    frame_vld = 0; sec_tick = 0; err_flag_clr = 0;
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] r, input string ph);
    frame_vld = 1; calc_par = c; rx_par = r; cyc(ph);
  endtask

  task automatic tick(input bit clr, input string ph);
    sec_tick = 1; clr_on_xfer = clr; cyc(ph);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;

    // R2 R3: worked example 0x5A vs 0x1D -> 4 bits, 1 block
    frame(8'h5A, 8'h1D, "R2 example");
    frame(8'h33, 8'h33, "R3 equal bytes");
    tick(1, "R2 R3 example transfer");
    check(bit_err_snap == 24'd4, "R2", "example", bit_err_snap, 4);
    check(blk_err_snap == 20'd1, "R3", "example", blk_err_snap, 1);

    // R4 R5: frame coincident with clearing tick goes into new interval
    frame(8'hFF, 8'h00, "R5 prep");
    sec_tick = 1; clr_on_xfer = 1; frame_vld = 1; calc_par = 8'h0F; rx_par = 8'h00;
    cyc("R4 R5 same-cycle frame");
    check(bit_err_snap == 24'd8, "R4", "snap excludes same-cycle frame", bit_err_snap, 8);
    tick(1, "R5 new interval");
    check(bit_err_snap == 24'd4, "R5", "frame in new interval", bit_err_snap, 4);

    // R5 retain mode
    frame(8'h01, 8'h00, "R5 retain a");
    tick(0, "R5 retain t1");
    frame(8'h03, 8'h00, "R5 retain b");
    tick(0, "R5 retain t2");
    check(bit_err_snap == 24'd3, "R5", "retained total", bit_err_snap, 3);
    tick(1, "R5 flush");

    // R6 R7 pauses; R9 paused frame does not set flag
    err_flag_clr = 1; cyc("R9 clear");
    lof = 1; frame(8'hFF, 8'h00, "R6 lof"); lof = 0;
    los = 1; frame(8'hFF, 8'h00, "R6 los"); los = 0;
    oof = 1; oof_pause_en = 1; frame(8'hFF, 8'h00, "R7 oof enabled");
    iae = 1; iae_pause_en = 1; oof_pause_en = 0; oof = 0;
    frame(8'hFF, 8'h00, "R7 iae enabled");
    check(err_flag == 1'b0, "R9", "paused frames leave flag", err_flag, 0);
    iae_pause_en = 0; frame(8'h01, 8'h00, "R7 iae ignored"); iae = 0;
    oof = 1; frame(8'h03, 8'h00, "R7 oof ignored"); oof = 0;
    tick(1, "R6 R7 transfer");
    check(bit_err_snap == 24'd3, "R7", "only unpaused counted", bit_err_snap, 3);

    // R9 set wins over clear; R10 mask
    err_irq_mask = 1;
    err_flag_clr = 1; frame(8'h80, 8'h00, "R9 set wins");
    check(err_flag == 1'b1, "R9", "set beats clear", err_flag, 1);
    check(err_irq == 1'b1, "R10", "mask on", err_irq, 1);
    err_irq_mask = 0; #1;
    check(err_irq == 1'b0, "R10", "mask off", err_irq, 0);

    // R8 saturation on narrow instance
    tick(1, "R8 flush");
    for (int i = 0; i < 20; i++) frame(8'hFF, 8'h00, "R8 fill");
    tick(0, "R8 transfer");
    check(s_bit_snap == 6'h3F, "R8", "bit saturate", s_bit_snap, 63);
    check(s_blk_snap == 4'hF, "R8", "block saturate", s_blk_snap, 15);
    tick(1, "R8 clear");

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      frame_vld    = ($urandom % 3) != 0;
      calc_par     = 8'($urandom);
      rx_par       = (($urandom % 2) == 0) ? calc_par : 8'($urandom);
      sec_tick     = ($urandom % 40) == 0;
      clr_on_xfer  = ($urandom % 2) == 0;
      lof          = ($urandom % 16) == 0;
      los          = ($urandom % 16) == 0;
      oof          = ($urandom % 6) == 0;
      oof_pause_en = $urandom % 2;
      iae          = ($urandom % 6) == 0;
      iae_pause_en = $urandom % 2;
      err_flag_clr = ($urandom % 5) == 0;
      err_irq_mask = $urandom % 2;
      cyc("R2 R3 R4 R5 R6 R7 R9 R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule